// File: doc/BRIEF.md
# GPIO Pin Event Interrupt Bank

This block watches 32 general-purpose input pins, already synchronized to its clock, and turns per-pin events into a single interrupt line for the bank. Software configures each pin through a small register interface. The settings per pin are: whether the pin takes part at all, whether it is masked from the interrupt, whether it triggers on an edge or a level, which polarity it looks for, and whether it should fire on every transition.

Edge events latch into a raw status register and stay there until software clears them. It clears an event by writing a one to the pin's position in the end-of-interrupt register. A level-triggered pin's raw status simply tracks the active level. The masked status is raw status with masked pins removed. Its OR, registered, drives the interrupt output. Each 32-bit register is reached as two word slots, low half at the base offset and high half at base + 4. The upper 16 bits of every written word act as a per-bit write enable for the lower 16. As a result, single pins can be changed without a read-modify-write.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset every configuration register, the raw status, the masked status and irq_o read as zero.
- R2: Register offsets are enable 0x10, mask 0x18, trigger type 0x20, polarity 0x28, any-edge 0x30, masked status 0x50, raw status 0x58 and event clear 0x60. Each register's bits 15:0 sit at the offset and bits 31:16 at offset + 4. A write changes lower-half bit k only where written data bit 16+k is 1. Reads return the half in [15:0] with [31:16] zero. Accesses with address bits 1:0 nonzero are ignored.
- R3: Consider an enabled pin with type 1 (edge), polarity 1 and any-edge 0. A 0-to-1 change sets its raw bit at the first clock edge that sees the new level. A 1-to-0 change sets nothing.
- R4: Consider an enabled pin with type 1, polarity 0 and any-edge 0. A 1-to-0 change sets its raw bit. A 0-to-1 change sets nothing.
- R5: For an enabled pin with any-edge 1, both transitions set its raw bit. Its polarity and type bits are ignored, and the event stays latched.
- R6: For an enabled pin with type 0 and any-edge 0, the raw bit equals the pin level when polarity is 1, and the inverted level when polarity is 0. This is delayed one clock, and writing the event-clear bit has no effect on it.
- R7: A pin whose enable bit is 0 holds raw bit 0, whatever its input does.
- R8: A mask bit of 1 leaves the raw bit unchanged and forces the masked-status bit to 0. In all cases, masked status = raw AND NOT mask.
- R9: Writing event clear with an effective 1 (data and write-enable both 1) clears that pin's latched edge event. Bits written 0, or without write enable, do not clear.
- R10: When a new qualifying edge arrives in the same cycle as the clear of that pin, the raw bit stays 1.
- R11: irq_o is 1 exactly one clock after any masked-status bit is 1, and 0 one clock after all are 0.
- R12: Writes to masked status and raw status have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Synchronized pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Byte address of the register word |
| reg_wdata | input | 32 | Write data: [31:16] bit enables, [15:0] values |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Combined bank interrupt, registered |

## Verification
Two functions can coincide on a single edge-triggered pin: detection of a new edge, and the software clear of the event already latched. The bench provokes this by driving the pin's qualifying transition on the same clock as the event-clear write for that pin. It judges that the raw bit still reads 1 afterwards. A second case covers the clear arriving with its write-enable bit off, where the latched event must also survive.

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       pin_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_MSK  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_TYP  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_POL  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFS_ANY  = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] OFS_RAW  = ADDR_W'('h58);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'('h60);

  logic [31:0] en_q, msk_q, typ_q, pol_q, any_q, raw_q, pin_q;
  logic [31:0] rise, fall, ehit, lvl, edge_mode, clr_vec, stat, sel;
  logic [ADDR_W-1:0] slot;
  logic hi, aligned, irq_q;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign hi      = reg_addr[2];
  assign slot    = {reg_addr[ADDR_W-1:3], 3'b000};

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic upper,
                                        input logic [31:0] wd);
    logic [31:0] r;
    r = cur;
    if (upper) r[31:16] = (cur[31:16] & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    else       r[15:0]  = (cur[15:0]  & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; msk_q <= '0; typ_q <= '0; pol_q <= '0; any_q <= '0;
    end else if (reg_we && aligned) begin
      if (slot == OFS_EN)  en_q  <= merge(en_q,  hi, reg_wdata);
      if (slot == OFS_MSK) msk_q <= merge(msk_q, hi, reg_wdata);
      if (slot == OFS_TYP) typ_q <= merge(typ_q, hi, reg_wdata);
      if (slot == OFS_POL) pol_q <= merge(pol_q, hi, reg_wdata);
      if (slot == OFS_ANY) any_q <= merge(any_q, hi, reg_wdata);
    end
  end

  assign clr_vec = (reg_we && aligned && slot == OFS_CLR)
                 ? (hi ? {reg_wdata[15:0] & reg_wdata[31:16], 16'h0}
                       : {16'h0, reg_wdata[15:0] & reg_wdata[31:16]})
                 : '0;

  assign rise      = pin_i & ~pin_q;
  assign fall      = ~pin_i & pin_q;
  assign edge_mode = typ_q | any_q;
  assign ehit      = en_q & edge_mode & ((any_q & (rise | fall)) |
                     (~any_q & ((pol_q & rise) | (~pol_q & fall))));
  assign lvl       = (pin_i & pol_q) | (~pin_i & ~pol_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= '0;
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      raw_q <= en_q & ((edge_mode & (ehit | (raw_q & ~clr_vec))) | (~edge_mode & lvl));
      irq_q <= |stat;
    end
  end

  assign stat  = raw_q & ~msk_q;
  assign irq_o = irq_q;

  always_comb begin
    case (slot)
      OFS_EN:   sel = en_q;
      OFS_MSK:  sel = msk_q;
      OFS_TYP:  sel = typ_q;
      OFS_POL:  sel = pol_q;
      OFS_ANY:  sel = any_q;
      OFS_STAT: sel = stat;
      OFS_RAW:  sel = raw_q;
      default:  sel = '0;
    endcase
    if (!aligned) reg_rdata = '0;
    else          reg_rdata = hi ? {16'h0, sel[31:16]} : {16'h0, sel[15:0]};
  end

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(en_q)) == '0));

  assert_edge_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ehit) & ~raw_q) == '0));

  assert_level_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((raw_q ^ $past(lvl)) & $past(en_q & ~edge_mode)) == '0));

  assert_edge_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & $past(en_q & edge_mode) & ~$past(ehit)) == '0));

  assert_irq_raise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~msk_q) != '0) |=> irq_o);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past((raw_q & ~msk_q) != '0));
endmodule

// File: tb/gpio_evt_bank_tb_top.sv
module gpio_evt_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_EN = 8'h10, A_MSK = 8'h18, A_TYP = 8'h20, A_POL = 8'h28,
                         A_ANY = 8'h30, A_STAT = 8'h50, A_RAW = 8'h58, A_CLR = 8'h60;

  logic clk = 0, rst_n = 0, reg_we = 0, irq_o;
  logic [31:0] pin_i = '0, reg_wdata = '0, reg_rdata;
  logic [7:0] reg_addr = '0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_evt_bank dut_i (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic set32(input logic [7:0] a, input logic [31:0] v);
    wr(a, {16'hFFFF, v[15:0]});
    wr(a + 8'h4, {16'hFFFF, v[31:16]});
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] v);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 8'h4, hi);
    v = {hi[15:0], lo[15:0]};
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk); pin_i = v;
    @(negedge clk);
  endtask

  task automatic clear_all;
    set32(A_EN, 0); set32(A_MSK, 0); set32(A_TYP, 0); set32(A_POL, 0); set32(A_ANY, 0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd32(A_EN, v);   chk("R1 enable", v, 0);
    rd32(A_MSK, v);  chk("R1 mask", v, 0);
    rd32(A_TYP, v);  chk("R1 type", v, 0);
    rd32(A_ANY, v);  chk("R1 any-edge", v, 0);
    rd32(A_RAW, v);  chk("R1 raw", v, 0);
    rd32(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_masked_write;
    logic [31:0] v;
    wr(A_POL, {16'h00FF, 16'hFFF0});
    rd(A_POL, v); chk("R2 enable-gated low half", v, 32'h0000_00F0);
    wr(A_POL, {16'h000F, 16'h0003});
    rd(A_POL, v); chk("R2 partial update keeps others", v, 32'h0000_00F3);
    wr(A_POL + 8'h4, {16'h8000, 16'h8000});
    rd(A_POL + 8'h4, v); chk("R2 high half", v, 32'h0000_8000);
    wr(A_POL + 8'h1, {16'hFFFF, 16'hFFFF});
    rd32(A_POL, v); chk("R2 misaligned ignored", v, 32'h8000_00F3);
    clear_all();
  endtask

  task automatic t_rising;
    logic [31:0] v;
    set32(A_TYP, 32'h1); set32(A_POL, 32'h1); set32(A_EN, 32'h1);
    pins(32'h1);
    rd32(A_RAW, v); chk("R3 rising latches", v, 32'h1);
    chk("R11 irq after status", {31'b0, irq_o}, 1);
    wr(A_CLR, {16'h0001, 16'h0001});
    rd32(A_RAW, v); chk("R9 clear", v, 0);
    @(negedge clk); chk("R11 irq drops", {31'b0, irq_o}, 0);
    pins(32'h0);
    rd32(A_RAW, v); chk("R3 falling ignored", v, 0);
    clear_all();
  endtask

  task automatic t_falling;
    logic [31:0] v;
    set32(A_TYP, 32'h2); set32(A_EN, 32'h2);
    pins(32'h2);
    rd32(A_RAW, v); chk("R4 rising ignored", v, 0);
    pins(32'h0);
    rd32(A_RAW, v); chk("R4 falling latches", v, 32'h2);
    clear_all();
  endtask

  task automatic t_any;
    logic [31:0] v;
    set32(A_TYP, 32'h0010_0000); set32(A_ANY, 32'h0030_0000); set32(A_EN, 32'h0030_0000);
    pins(32'h0010_0000);
    rd32(A_RAW, v); chk("R5 rise with polarity 0", v, 32'h0010_0000);
    wr(A_CLR + 8'h4, {16'h0010, 16'h0010});
    rd32(A_RAW, v); chk("R9 high-half clear", v, 0);
    pins(32'h0000_0000);
    rd32(A_RAW, v); chk("R5 fall", v, 32'h0010_0000);
    wr(A_CLR + 8'h4, {16'h0010, 16'h0010});
    pins(32'h0020_0000);
    @(negedge clk); @(negedge clk);
    rd32(A_RAW, v); chk("R5 type 0 pin latched", v, 32'h0020_0000);
    pins(32'h0);
    clear_all();
  endtask

  task automatic t_level;
    logic [31:0] v;
    set32(A_POL, 32'h20); set32(A_EN, 32'h60);
    rd32(A_RAW, v); chk("R6 active-low idle", v, 32'h40);
    pins(32'h20);
    rd32(A_RAW, v); chk("R6 active-high", v, 32'h60);
    wr(A_CLR, {16'h0060, 16'h0060});
    rd32(A_RAW, v); chk("R6 clear has no effect", v, 32'h60);
    pins(32'h40);
    rd32(A_RAW, v); chk("R6 follows level", v, 32'h0);
    pins(32'h0);
    clear_all();
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    set32(A_TYP, 32'h80); set32(A_POL, 32'h80); set32(A_ANY, 32'h80);
    pins(32'h80);
    rd32(A_RAW, v); chk("R7 no rise", v, 0);
    pins(32'h0);
    rd32(A_RAW, v); chk("R7 no fall", v, 0);
    chk("R7 irq quiet", {31'b0, irq_o}, 0);
    clear_all();
  endtask

  task automatic t_mask;
    logic [31:0] v;
    set32(A_TYP, 32'h100); set32(A_POL, 32'h100); set32(A_MSK, 32'h100); set32(A_EN, 32'h100);
    pins(32'h100);
    @(negedge clk);
    rd32(A_RAW, v);  chk("R8 raw unmasked", v, 32'h100);
    rd32(A_STAT, v); chk("R8 status masked", v, 0);
    chk("R8 irq blocked", {31'b0, irq_o}, 0);
    set32(A_MSK, 0);
    rd32(A_STAT, v); chk("R8 status after unmask", v, 32'h100);
    chk("R11 irq after unmask", {31'b0, irq_o}, 1);
    pins(32'h0);
    clear_all();
  endtask

  task automatic t_race;
    logic [31:0] v;
    set32(A_TYP, 32'h200); set32(A_POL, 32'h200); set32(A_EN, 32'h200);
    pins(32'h200);
    wr(A_CLR, {16'h0000, 16'h0200});
    rd32(A_RAW, v); chk("R9 clear without enable ignored", v, 32'h200);
    wr(A_CLR, {16'h0200, 16'h0000});
    rd32(A_RAW, v); chk("R9 zero data ignored", v, 32'h200);
    wr(A_RAW, {16'hFFFF, 16'h0000});
    wr(A_STAT, {16'hFFFF, 16'h0000});
    rd32(A_RAW, v); chk("R12 read-only status", v, 32'h200);
    pins(32'h0);
    @(negedge clk); pin_i = 32'h200; reg_we = 1; reg_addr = A_CLR; reg_wdata = {16'h0200, 16'h0200};
    @(negedge clk); reg_we = 0; reg_wdata = '0;
    rd32(A_RAW, v); chk("R10 new edge beats clear", v, 32'h200);
    pins(32'h0);
    clear_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masked_write();
    t_rising();
    t_falling();
    t_any();
    t_level();
    t_disabled();
    t_mask();
    t_race();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule